// File: doc/BRIEF.md
# Compare and Condition-Register Unit

This unit owns a 32-bit condition word split into eight 4-bit fields. Every operation that writes the word runs here. Compares come in signed and unsigned forms, with the right-hand operand taken from a register or from a 16-bit immediate. Bit-combine operations read two single bits of the word and write one. There is also a field-to-field copy, a nibble-masked load from a general register, and a read that returns the whole word on a separate result port.

Bits are numbered big-endian. Index b (0..31) lives at physical position 31-b. Field f (0..7) spans physical bits 31-4f down to 28-4f. Inside a field, from most to least significant, the bits are less-than, greater-than, equal and summary-overflow.

Operations arrive on a valid/ready input channel, one per cycle. Read results leave on a valid/ready output channel that holds a single entry. While that entry waits with `rd_ready` low, `in_ready` drops and the input channel stalls. Every other pin is plain control or data.

Top module: `cond_reg_unit`

## Requirements
- R1: After reset, `cr_value` is 0 and `rd_valid` is 0.
- R2: Opcode 0 compares `opa` and `opb` as signed 32-bit values.
- R3: Opcode 1 compares `opa` and `opb` as unsigned 32-bit values.
- R4: Opcode 2 compares `opa` with `imm` sign-extended to 32 bits, signed. Opcode 3 compares `opa` with `imm` zero-extended, unsigned.
- R5: A compare writes the 4-bit value {lt,gt,eq,so_flag} into field `fld_dst`, with exactly one of lt/gt/eq set. All other fields are unchanged.
- R6: Opcode 4 writes bit `bit_t` (big-endian index) with f(bit `bit_a`, bit `bit_b`). The function is chosen by `bit_fn`: 0 and, 1 or, 2 nand, 3 xor, 4 nor, 5 equality, 6 a-and-not-b, 7 a-or-not-b. All other bits are unchanged.
- R7: Opcode 5 copies field `fld_src` into field `fld_dst`. When the two indices are equal, the word is unchanged.
- R8: Opcode 6 loads nibble i (physical bits 4i+3..4i) from `opa` wherever `fmask[i]` is 1 and keeps the other nibbles. A zero mask leaves the word unchanged.
- R9: Opcode 7 leaves the word unchanged. On the next edge it sets `rd_valid` and makes `rd_data` equal to the word as it was when the read was accepted.
- R10: While `rd_valid` is 1 and `rd_ready` is 0, `in_ready` is 0, and `rd_valid` and `rd_data` hold. No operation is accepted, so `cr_value` does not change.
- R11: An operation is accepted when `in_valid` and `in_ready` are both 1. Its effect appears on `cr_value` after the next rising edge. Without an accept, `cr_value` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Unit can take an operation |
| in_op | input | 3 | Opcode 0..7 as in R2-R9 |
| bit_fn | input | 3 | Bit-combine function select |
| opa | input | 32 | First operand / masked-load source |
| opb | input | 32 | Second register operand |
| imm | input | 16 | Immediate operand |
| so_flag | input | 1 | Sticky summary-overflow flag |
| fld_dst | input | 3 | Destination field index |
| fld_src | input | 3 | Source field index |
| bit_a | input | 5 | First source bit index |
| bit_b | input | 5 | Second source bit index |
| bit_t | input | 5 | Target bit index |
| fmask | input | 8 | Nibble write mask |
| cr_value | output | 32 | Current condition word |
| rd_valid | output | 1 | Read result present |
| rd_ready | input | 1 | Consumer takes read result |
| rd_data | output | 32 | Read result |

## Verification
The embedded checks assume the operand inputs carry known values whenever the compare path is evaluated. The onehot check on the compare result is skipped while operands are unknown. The bench drives every input to a defined value from the first cycle, so this always holds. The checks also assume `in_op` and its operands stay stable across the edge where an accept happens. The bench changes inputs only at falling edges. Back-pressure is exercised by holding `rd_ready` low after a read while further operations are offered. A later random phase toggles `rd_ready` freely.

// File: rtl/cru_pkg.sv
`timescale 1ns/1ps
package cru_pkg;
  typedef enum logic [2:0] {
    OPC_CMP_S  = 3'd0,
    OPC_CMP_U  = 3'd1,
    OPC_CMPI_S = 3'd2,
    OPC_CMPI_U = 3'd3,
    OPC_BITOP  = 3'd4,
    OPC_FCOPY  = 3'd5,
    OPC_MASKW  = 3'd6,
    OPC_READ   = 3'd7
  } cru_op_e;

  typedef enum logic [2:0] {
    BF_AND  = 3'd0,
    BF_OR   = 3'd1,
    BF_NAND = 3'd2,
    BF_XOR  = 3'd3,
    BF_NOR  = 3'd4,
    BF_EQV  = 3'd5,
    BF_ANDC = 3'd6,
    BF_ORC  = 3'd7
  } cru_bitfn_e;
endpackage

// File: rtl/cru_cmp.sv
`timescale 1ns/1ps
module cru_cmp #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16
) (
  input  logic             use_imm,
  input  logic             is_unsigned,
  input  logic [XLEN-1:0]  opa,
  input  logic [XLEN-1:0]  opb,
  input  logic [IMM_W-1:0] imm,
  input  logic             so,
  output logic [3:0]       fld
);
  logic [XLEN-1:0] rhs;
  logic lt, gt, eq;

  always_comb begin
    if (!use_imm)         rhs = opb;
    else if (is_unsigned) rhs = {{(XLEN-IMM_W){1'b0}}, imm};
    else                  rhs = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
  end

  always_comb begin
    eq = (opa == rhs);
    if (is_unsigned) begin
      lt = opa < rhs;
      gt = opa > rhs;
    end else begin
      lt = $signed(opa) < $signed(rhs);
      gt = $signed(opa) > $signed(rhs);
    end
    fld = {lt, gt, eq, so};
  end

  // R5: exactly one relation bit set
  always_comb begin
    if (!$isunknown({opa, rhs, is_unsigned})) begin
      assert_cmp_onehot_R5: assert ($onehot({lt, gt, eq}));
    end
  end
endmodule

// File: rtl/cru_bitop.sv
`timescale 1ns/1ps
module cru_bitop
  import cru_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]         cr_in,
  input  logic [2:0]              func,
  input  logic [$clog2(XLEN)-1:0] ba,
  input  logic [$clog2(XLEN)-1:0] bb,
  input  logic [$clog2(XLEN)-1:0] bt,
  output logic [XLEN-1:0]         cr_out
);
  localparam int BIDX_W = $clog2(XLEN);
  localparam logic [BIDX_W-1:0] LAST = BIDX_W'(XLEN-1);

  logic a, b, r;

  always_comb begin
    a = cr_in[LAST - ba];
    b = cr_in[LAST - bb];
    unique case (cru_bitfn_e'(func))
      BF_AND:  r = a & b;
      BF_OR:   r = a | b;
      BF_NAND: r = ~(a & b);
      BF_XOR:  r = a ^ b;
      BF_NOR:  r = ~(a | b);
      BF_EQV:  r = ~(a ^ b);
      BF_ANDC: r = a & ~b;
      BF_ORC:  r = a | ~b;
      default: r = 1'b0;
    endcase
    cr_out = cr_in;
    cr_out[LAST - bt] = r;
  end
endmodule

// File: rtl/cru_fieldops.sv
`timescale 1ns/1ps
module cru_fieldops #(
  parameter int XLEN    = 32,
  parameter int NFIELDS = 8
) (
  input  logic [XLEN-1:0]            cr_in,
  input  logic [$clog2(NFIELDS)-1:0] src_idx,
  input  logic [$clog2(NFIELDS)-1:0] dst_idx,
  input  logic [XLEN/NFIELDS-1:0]    ins_val,
  input  logic [NFIELDS-1:0]         mask,
  input  logic [XLEN-1:0]            wdata,
  output logic [XLEN/NFIELDS-1:0]    src_nib,
  output logic [XLEN-1:0]            ins_out,
  output logic [XLEN-1:0]            mask_out
);
  localparam int FW     = XLEN / NFIELDS;
  localparam int FIDX_W = $clog2(NFIELDS);

  // big-endian field f sits in physical nibble NFIELDS-1-f
  always_comb begin
    src_nib = '0;
    for (int g = 0; g < NFIELDS; g++) begin
      if (src_idx == FIDX_W'(NFIELDS-1-g)) src_nib = cr_in[g*FW +: FW];
    end
  end

  for (genvar g = 0; g < NFIELDS; g++) begin : g_nib
    assign ins_out[g*FW +: FW]  = (dst_idx == FIDX_W'(NFIELDS-1-g)) ? ins_val : cr_in[g*FW +: FW];
    assign mask_out[g*FW +: FW] = mask[g] ? wdata[g*FW +: FW] : cr_in[g*FW +: FW];
  end
endmodule

// File: rtl/cond_reg_unit.sv
`timescale 1ns/1ps
module cond_reg_unit
  import cru_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int IMM_W   = 16,
  parameter int NFIELDS = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [2:0]                 in_op,
  input  logic [2:0]                 bit_fn,
  input  logic [XLEN-1:0]            opa,
  input  logic [XLEN-1:0]            opb,
  input  logic [IMM_W-1:0]           imm,
  input  logic                       so_flag,
  input  logic [$clog2(NFIELDS)-1:0] fld_dst,
  input  logic [$clog2(NFIELDS)-1:0] fld_src,
  input  logic [$clog2(XLEN)-1:0]    bit_a,
  input  logic [$clog2(XLEN)-1:0]    bit_b,
  input  logic [$clog2(XLEN)-1:0]    bit_t,
  input  logic [NFIELDS-1:0]         fmask,
  output logic [XLEN-1:0]            cr_value,
  output logic                       rd_valid,
  input  logic                       rd_ready,
  output logic [XLEN-1:0]            rd_data
);
  localparam int FW = XLEN / NFIELDS;

  cru_op_e         op;
  logic [XLEN-1:0] cr_q, cr_next, rd_q;
  logic            rdv_q, fire;
  logic [3:0]      cmp_fld;
  logic [FW-1:0]   src_nib, ins_val;
  logic [XLEN-1:0] bit_out, ins_out, mask_out;

  assign op       = cru_op_e'(in_op);
  assign in_ready = !rdv_q || rd_ready;
  assign fire     = in_valid && in_ready;

  cru_cmp #(.XLEN(XLEN), .IMM_W(IMM_W)) u_cmp (
    .use_imm(in_op[1]), .is_unsigned(in_op[0]), .opa(opa), .opb(opb),
    .imm(imm), .so(so_flag), .fld(cmp_fld)
  );

  cru_bitop #(.XLEN(XLEN)) u_bitop (
    .cr_in(cr_q), .func(bit_fn), .ba(bit_a), .bb(bit_b), .bt(bit_t),
    .cr_out(bit_out)
  );

  assign ins_val = (op == OPC_FCOPY) ? src_nib : FW'(cmp_fld);

  cru_fieldops #(.XLEN(XLEN), .NFIELDS(NFIELDS)) u_fld (
    .cr_in(cr_q), .src_idx(fld_src), .dst_idx(fld_dst), .ins_val(ins_val),
    .mask(fmask), .wdata(opa), .src_nib(src_nib), .ins_out(ins_out),
    .mask_out(mask_out)
  );

  always_comb begin
    unique case (op)
      OPC_CMP_S, OPC_CMP_U, OPC_CMPI_S, OPC_CMPI_U, OPC_FCOPY: cr_next = ins_out;
      OPC_BITOP: cr_next = bit_out;
      OPC_MASKW: cr_next = mask_out;
      default:   cr_next = cr_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cr_q  <= '0;
      rdv_q <= 1'b0;
      rd_q  <= '0;
    end else begin
      if (fire) cr_q <= cr_next;
      if (fire && op == OPC_READ) begin
        rdv_q <= 1'b1;
        rd_q  <= cr_q;
      end else if (rd_ready) begin
        rdv_q <= 1'b0;
      end
    end
  end

  assign cr_value = cr_q;
  assign rd_valid = rdv_q;
  assign rd_data  = rd_q;

  assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(cr_value));

  assert_read_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op == 3'd7) |=> (rd_valid && rd_data == $past(cr_value)));

  assert_rd_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  assert_mask_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op == 3'd6 && fmask == '0) |=> $stable(cr_value));

  assert_copy_self_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op == 3'd5 && fld_src == fld_dst) |=> $stable(cr_value));
endmodule

// File: tb/cond_reg_unit_tb_top.sv
`timescale 1ns/1ps
module cond_reg_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, rd_ready = 1'b1, so_flag = 1'b0;
  logic [2:0]  in_op = 3'd0, bit_fn = 3'd0, fld_dst = 3'd0, fld_src = 3'd0;
  logic [31:0] opa = '0, opb = '0;
  logic [15:0] imm = '0;
  logic [4:0]  bit_a = '0, bit_b = '0, bit_t = '0;
  logic [7:0]  fmask = '0;
  logic        in_ready, rd_valid;
  logic [31:0] cr_value, rd_data;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;
  string tag = "R1";

  logic [31:0] m_cr = '0, m_rd = '0;
  logic        m_rv = 1'b0;

  always #4 clk = ~clk;

  cond_reg_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .bit_fn(bit_fn), .opa(opa), .opb(opb), .imm(imm),
    .so_flag(so_flag), .fld_dst(fld_dst), .fld_src(fld_src), .bit_a(bit_a),
    .bit_b(bit_b), .bit_t(bit_t), .fmask(fmask), .cr_value(cr_value),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
  );

  task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  function automatic logic [3:0] ref_cmp(logic [2:0] o, logic [31:0] a, logic [31:0] b,
                                         logic [15:0] im, logic so);
    longint x, y;
    if (o[0]) begin
      x = longint'({32'b0, a});
      y = o[1] ? longint'({48'b0, im}) : longint'({32'b0, b});
    end else begin
      x = longint'($signed(a));
      y = o[1] ? longint'($signed(im)) : longint'($signed(b));
    end
    if (x < y)      return {3'b100, so};
    else if (x > y) return {3'b010, so};
    else            return {3'b001, so};
  endfunction

  task automatic model_step();
    logic rdy, a, b, r;
    logic [31:0] nxt;
    rdy = !m_rv || rd_ready;
    nxt = m_cr;
    if (in_valid && rdy) begin
      case (in_op)
        3'd0, 3'd1, 3'd2, 3'd3: nxt[31-4*fld_dst -: 4] = ref_cmp(in_op, opa, opb, imm, so_flag);
        3'd4: begin
          a = m_cr[31-bit_a];
          b = m_cr[31-bit_b];
          case (bit_fn)
            3'd0: r = a && b;
            3'd1: r = a || b;
            3'd2: r = !(a && b);
            3'd3: r = (a != b);
            3'd4: r = !(a || b);
            3'd5: r = (a == b);
            3'd6: r = a && !b;
            default: r = a || !b;
          endcase
          nxt[31-bit_t] = r;
        end
        3'd5: nxt[31-4*fld_dst -: 4] = m_cr[31-4*fld_src -: 4];
        3'd6: for (int i = 0; i < 8; i++) if (fmask[i]) nxt[4*i +: 4] = opa[4*i +: 4];
        default: ;
      endcase
      if (in_op == 3'd7) begin
        m_rv = 1'b1;
        m_rd = m_cr;
      end else if (rd_ready) m_rv = 1'b0;
    end else if (rd_ready) m_rv = 1'b0;
    m_cr = nxt;
  endtask

  task automatic cycle();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(tag, cr_value, m_cr);
    chk({tag, " R10 rd_valid"}, {31'b0, rd_valid}, {31'b0, m_rv});
    if (m_rv) chk({tag, " R9 rd_data"}, rd_data, m_rd);
    chk("R10 in_ready", {31'b0, in_ready}, {31'b0, (!m_rv || rd_ready)});
  endtask

  task automatic op(string t, logic [2:0] o, logic [31:0] a, logic [31:0] b, logic [15:0] im,
                    logic so, logic [2:0] d, logic [2:0] s, logic [2:0] fn,
                    logic [4:0] xa, logic [4:0] xb, logic [4:0] xt, logic [7:0] m);
    tag = t; in_valid = 1'b1; in_op = o; opa = a; opb = b; imm = im; so_flag = so;
    fld_dst = d; fld_src = s; bit_fn = fn; bit_a = xa; bit_b = xb; bit_t = xt; fmask = m;
    cycle();
    in_valid = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 cr reset", cr_value, 32'h0);
    chk("R1 rd_valid reset", {31'b0, rd_valid}, 32'h0);
    // R2 signed: -5 < 3 -> field0 = 1000
    op("R2 R5", 3'd0, 32'hFFFF_FFFB, 32'd3, 16'h0, 1'b0, 3'd0, 3'd0, 3'd0, 0, 0, 0, 8'h0);
    // R3 unsigned: 0xFFFFFFFB > 3 -> field1 = 0100
    op("R3 R5", 3'd1, 32'hFFFF_FFFB, 32'd3, 16'h0, 1'b0, 3'd1, 3'd0, 3'd0, 0, 0, 0, 8'h0);
    // R4 immediate sign vs zero extension of 0x8000
    op("R4 signed imm", 3'd2, 32'd0, 32'd0, 16'h8000, 1'b0, 3'd2, 3'd0, 3'd0, 0, 0, 0, 8'h0);
    op("R4 unsigned imm", 3'd3, 32'd0, 32'd0, 16'h8000, 1'b0, 3'd3, 3'd0, 3'd0, 0, 0, 0, 8'h0);
    op("R4 imm eq", 3'd2, 32'hFFFF_FFFF, 32'd0, 16'hFFFF, 1'b1, 3'd4, 3'd0, 3'd0, 0, 0, 0, 8'h0);
    // R5 equal with summary-overflow into last field
    op("R5 eq so", 3'd0, 32'h1234, 32'h1234, 16'h0, 1'b1, 3'd7, 3'd0, 3'd0, 0, 0, 0, 8'h0);
    op("R2 max vs min", 3'd0, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0, 1'b0, 3'd5, 3'd0, 3'd0, 0, 0, 0, 8'h0);
    // R6 all eight functions on a mix of bit pairs
    for (int f = 0; f < 8; f++) begin
      op("R6", 3'd4, 0, 0, 0, 1'b0, 0, 0, 3'(f), 5'd0, 5'd5, 5'(8 + f), 8'h0);
      op("R6", 3'd4, 0, 0, 0, 1'b0, 0, 0, 3'(f), 5'd1, 5'd2, 5'(31 - f), 8'h0);
    end
    // R7 field copies, including self-copy
    op("R7", 3'd5, 0, 0, 0, 1'b0, 3'd6, 3'd0, 0, 0, 0, 0, 8'h0);
    op("R7 self", 3'd5, 0, 0, 0, 1'b0, 3'd3, 3'd3, 0, 0, 0, 0, 8'h0);
    // R8 masked loads
    op("R8 zero mask", 3'd6, 32'hDEAD_BEEF, 0, 0, 1'b0, 0, 0, 0, 0, 0, 0, 8'h00);
    op("R8 partial", 3'd6, 32'hDEAD_BEEF, 0, 0, 1'b0, 0, 0, 0, 0, 0, 0, 8'hA5);
    op("R8 full", 3'd6, 32'h0F1E_2D3C, 0, 0, 1'b0, 0, 0, 0, 0, 0, 0, 8'hFF);
    // R9 read, then R10 back-pressure
    rd_ready = 1'b0;
    op("R9 read", 3'd7, 0, 0, 0, 1'b0, 0, 0, 0, 0, 0, 0, 8'h0);
    op("R10 blocked", 3'd6, 32'h0, 0, 0, 1'b0, 0, 0, 0, 0, 0, 0, 8'hFF);
    op("R10 blocked", 3'd0, 32'h1, 32'h2, 0, 1'b1, 3'd2, 0, 0, 0, 0, 0, 8'h0);
    tag = "R10 hold"; cycle();
    rd_ready = 1'b1;
    op("R11 resume", 3'd6, 32'h0, 0, 0, 1'b0, 0, 0, 0, 0, 0, 0, 8'h0F);
    op("R9 read2", 3'd7, 0, 0, 0, 1'b0, 0, 0, 0, 0, 0, 0, 8'h0);
    tag = "R11 idle"; cycle();
    // random phase
    for (int k = 0; k < 3000; k++) begin
      tag = "R11 random";
      in_valid = ($urandom_range(0, 3) != 0);
      rd_ready = ($urandom_range(0, 9) < 7);
      in_op = 3'($urandom); bit_fn = 3'($urandom);
      opa = $urandom; opb = ($urandom_range(0, 3) == 0) ? opa : $urandom;
      imm = 16'($urandom); so_flag = 1'($urandom);
      fld_dst = 3'($urandom); fld_src = 3'($urandom);
      bit_a = 5'($urandom); bit_b = 5'($urandom); bit_t = 5'($urandom);
      fmask = 8'($urandom);
      cycle();
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule